// File: doc/BRIEF.md
# Frequency Ramp Limiter

This block sits between a timing loop's target frequency-offset word and the control word of a clock synthesizer. When the loop switches to a new reference that comes from an unrelated source, the target can jump. The limiter turns that jump into a ramp. On each update tick the output moves toward the target by no more than a programmed maximum step, so equipment downstream of the clock sees no frequency transient large enough to pull it out of lock.

Slave operation in a redundant pair is handled differently. The standby unit must lock to its partner as fast as possible, so a slave flag bypasses the limit. While the flag is set, the output copies the target on every clock, without waiting for a tick. A step setting of zero also turns limiting off. A status bit reports whether the output still differs from the target after the most recent update.

All words are signed two's complement. The stepping arithmetic cannot wrap around the representable range and never carries the output past the target.

Top module: `freq_slew_limiter`

## Requirements
- R1: While `rst_n` is low, `out_word` is 0 and `ramping` is 0.
- R2: An update with `en`=1, `tick`=1, `slave`=0 and nonzero `max_step` (read as unsigned) applies when |`tgt_word` − `out_word`| > `max_step`. On the following clock edge `out_word` moves by exactly `max_step` in the direction of `tgt_word`.
- R3: The same update with |`tgt_word` − `out_word`| ≤ `max_step` makes `out_word` equal `tgt_word` on the following edge.
- R4: With `max_step` = 0, a tick with `en`=1 copies `tgt_word` straight into `out_word`.
- R5: With `en`=1 and `slave`=1, `out_word` takes the value `tgt_word` had one cycle earlier, on every clock, whether or not `tick` is high and whatever `max_step` holds.
- R6: With `en`=0, `tick`, `slave`, `tgt_word` and `max_step` have no effect. `out_word` and `ramping` hold their values. They also hold when `en`=1 but neither `tick` nor `slave` is high.
- R7: After each update `ramping` is 1 exactly when the new `out_word` differs from the `tgt_word` sampled at that update. Between updates it holds.
- R8: The words are signed two's complement of `WORD_W` bits. A limited update leaves `out_word` between its previous value and the target, inclusive. It never wraps, even for a ramp from the most positive to the most negative value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tgt_word | input | WORD_W | Signed target frequency-offset word from the loop |
| tick | input | 1 | Update strobe for limited operation |
| max_step | input | STEP_W | Unsigned largest change per tick; 0 disables limiting |
| en | input | 1 | Update enable; when low the output freezes |
| slave | input | 1 | Slave-mode bypass: follow the target every clock |
| out_word | output | WORD_W | Signed limited control word |
| ramping | output | 1 | Output differed from target after the last update |

## Verification
The bench provokes two kinds of collision.

- **Slave flag and tick together.** The slave flag is raised in the same cycle as a tick, in the middle of a long ramp. The bypass must win: the output snaps to the target instead of taking one more step.
- **Step change at a tick.** `max_step` is changed in the same cycle as a tick. The new limit must govern that very update.

A behavioural model in the bench sees the same inputs at each edge and predicts the output word and the status bit. Each collision is judged against that model on the clocks that follow. A large step from the positive extreme to the negative extreme checks that the arithmetic does not wrap.

// File: rtl/fsl_pkg.sv
package fsl_pkg;
   typedef enum logic [1:0] {
      UPD_HOLD   = 2'd0,
      UPD_LIMIT  = 2'd1,
      UPD_DIRECT = 2'd2
   } upd_kind_t;
endpackage

// File: rtl/fsl_delta.sv
module fsl_delta #(
   parameter int WORD_W = 32
) (
   input  logic signed [WORD_W-1:0] tgt,
   input  logic signed [WORD_W-1:0] cur,
   output logic signed [WORD_W:0]   diff,
   output logic        [WORD_W:0]   mag,
   output logic                     dir_neg
);
   localparam int DW = WORD_W + 1;

   logic signed [DW-1:0] tgt_x, cur_x;

   always_comb begin
      tgt_x   = {tgt[WORD_W-1], tgt};
      cur_x   = {cur[WORD_W-1], cur};
      diff    = tgt_x - cur_x;
      dir_neg = diff[DW-1];
      mag     = dir_neg ? DW'(-diff) : DW'(diff);
   end
endmodule

// File: rtl/fsl_stepper.sv
module fsl_stepper
   import fsl_pkg::*;
#(
   parameter int WORD_W      = 32,
   parameter int STEP_W      = 24,
   parameter bit CLAMP_GUARD = 1'b1
) (
   input  logic signed [WORD_W-1:0] cur,
   input  logic signed [WORD_W-1:0] tgt,
   input  logic        [WORD_W:0]   mag,
   input  logic                     dir_neg,
   input  logic        [STEP_W-1:0] step,
   input  upd_kind_t                kind,
   output logic signed [WORD_W-1:0] nxt
);
   localparam int DW = WORD_W + 1;
   localparam int EW = WORD_W + 2;
   localparam logic signed [EW-1:0] MAXV = {3'b000, {(WORD_W-1){1'b1}}};
   localparam logic signed [EW-1:0] MINV = {3'b111, {(WORD_W-1){1'b0}}};

   logic        [DW-1:0]     step_d;
   logic signed [EW-1:0]     step_e, cur_e, sum_e;
   logic signed [WORD_W-1:0] stepped;
   logic                     beyond;

   always_comb begin
      step_d = {{(DW-STEP_W){1'b0}}, step};
      step_e = {{(EW-STEP_W){1'b0}}, step};
      cur_e  = {{2{cur[WORD_W-1]}}, cur};
      sum_e  = dir_neg ? (cur_e - step_e) : (cur_e + step_e);
      beyond = mag > step_d;
   end

   generate
      if (CLAMP_GUARD) begin : g_clamp
         always_comb begin
            if (sum_e > MAXV)      stepped = MAXV[WORD_W-1:0];
            else if (sum_e < MINV) stepped = MINV[WORD_W-1:0];
            else                   stepped = sum_e[WORD_W-1:0];
         end
      end else begin : g_trunc
         always_comb stepped = sum_e[WORD_W-1:0];
      end
   endgenerate

   always_comb begin
      unique case (kind)
         UPD_LIMIT:  nxt = beyond ? stepped : tgt;
         UPD_DIRECT: nxt = tgt;
         default:    nxt = cur;
      endcase
   end
endmodule

// File: rtl/fsl_state.sv
module fsl_state #(
   parameter int WORD_W = 32,
   parameter logic signed [WORD_W-1:0] RESET_VAL = '0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     upd,
   input  logic signed [WORD_W-1:0] nxt,
   input  logic signed [WORD_W-1:0] tgt,
   output logic signed [WORD_W-1:0] word_q,
   output logic                     ramp_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= RESET_VAL;
         ramp_q <= 1'b0;
      end else if (upd) begin
         word_q <= nxt;
         ramp_q <= (nxt != tgt);
      end
   end

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> ($stable(word_q) && $stable(ramp_q)));
endmodule

// File: rtl/freq_slew_limiter.sv
module freq_slew_limiter
   import fsl_pkg::*;
#(
   parameter int WORD_W      = 32,
   parameter int STEP_W      = 24,
   parameter bit CLAMP_GUARD = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic signed [WORD_W-1:0] tgt_word,
   input  logic                     tick,
   input  logic        [STEP_W-1:0] max_step,
   input  logic                     en,
   input  logic                     slave,
   output logic signed [WORD_W-1:0] out_word,
   output logic                     ramping
);
   localparam int DW = WORD_W + 1;

   generate
      if (WORD_W < 4) begin : g_bad_word
         $error("freq_slew_limiter: WORD_W must be at least 4");
      end
      if (STEP_W < 1 || STEP_W > WORD_W) begin : g_bad_step
         $error("freq_slew_limiter: STEP_W must lie in 1..WORD_W");
      end
   endgenerate

   logic signed [DW-1:0]     diff;
   logic        [DW-1:0]     mag;
   logic                     dir_neg;
   logic signed [WORD_W-1:0] nxt;
   logic                     upd;
   upd_kind_t                kind;

   always_comb begin
      upd = en && (tick || slave);
      if (!upd)                         kind = UPD_HOLD;
      else if (slave || max_step == '0) kind = UPD_DIRECT;
      else                              kind = UPD_LIMIT;
   end

   fsl_delta #(.WORD_W(WORD_W)) u_delta (
      .tgt(tgt_word), .cur(out_word), .diff(diff), .mag(mag), .dir_neg(dir_neg)
   );

   fsl_stepper #(.WORD_W(WORD_W), .STEP_W(STEP_W), .CLAMP_GUARD(CLAMP_GUARD)) u_step (
      .cur(out_word), .tgt(tgt_word), .mag(mag), .dir_neg(dir_neg),
      .step(max_step), .kind(kind), .nxt(nxt)
   );

   fsl_state #(.WORD_W(WORD_W), .RESET_VAL('0)) u_state (
      .clk(clk), .rst_n(rst_n), .upd(upd), .nxt(nxt), .tgt(tgt_word),
      .word_q(out_word), .ramp_q(ramping)
   );

   // Assertion support: previous-cycle snapshot of the update inputs
   logic signed [WORD_W-1:0] a_out_p, a_tgt_p;
   logic        [STEP_W-1:0] a_step_p;
   logic                     a_lim_p;
   logic signed [DW-1:0]     a_move;
   logic        [DW-1:0]     a_move_mag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_out_p  <= '0;
         a_tgt_p  <= '0;
         a_step_p <= '0;
         a_lim_p  <= 1'b0;
      end else begin
         a_out_p  <= out_word;
         a_tgt_p  <= tgt_word;
         a_step_p <= max_step;
         a_lim_p  <= en && tick && !slave && (max_step != '0);
      end
   end

   always_comb begin
      a_move     = {out_word[WORD_W-1], out_word} - {a_out_p[WORD_W-1], a_out_p};
      a_move_mag = a_move[DW-1] ? DW'(-a_move) : DW'(a_move);
   end

   always_comb begin
      if (!rst_n) begin
         p_reset_r1: assert (out_word == '0 && ramping == 1'b0);
      end
   end

   p_step_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      a_lim_p |-> (a_move_mag <= {{(DW-STEP_W){1'b0}}, a_step_p}));

   p_zero_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick && max_step == '0) |=> (out_word == $past(tgt_word)));

   p_slave_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && slave) |=> (out_word == $past(tgt_word)));

   p_ramp_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && (tick || slave)) |=> (ramping == (out_word != $past(tgt_word))));

   p_no_overshoot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      a_lim_p |-> ((a_tgt_p >= a_out_p) ? (out_word >= a_out_p && out_word <= a_tgt_p)
                                        : (out_word <= a_out_p && out_word >= a_tgt_p)));
endmodule

// File: tb/sim_freq_slew_limiter.sv
module sim_freq_slew_limiter;
   localparam int W = 32;
   localparam int S = 24;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic signed [W-1:0] tgt_word = '0;
   logic                tick = 1'b0;
   logic [S-1:0]        max_step = '0;
   logic                en = 1'b0;
   logic                slave = 1'b0;
   logic signed [W-1:0] out_word;
   logic                ramping;

   int    n_chk = 0;
   int    n_fail = 0;
   int    cyc = 0;
   string tag = "R1";

   freq_slew_limiter #(.WORD_W(W), .STEP_W(S)) u0 (
      .clk(clk), .rst_n(rst_n), .tgt_word(tgt_word), .tick(tick),
      .max_step(max_step), .en(en), .slave(slave),
      .out_word(out_word), .ramping(ramping)
   );

   always #5 clk = ~clk;

   // Behavioural reference model
   longint m_out = 0;
   bit     m_ramp = 1'b0;
   longint t_v, d_v, s_v, n_v;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_out  = 0;
         m_ramp = 1'b0;
      end else if (en && (tick || slave)) begin
         t_v = longint'(tgt_word);
         s_v = longint'(max_step);
         d_v = t_v - m_out;
         if (slave || s_v == 0) n_v = t_v;
         else if (d_v > s_v)    n_v = m_out + s_v;
         else if (d_v < -s_v)   n_v = m_out - s_v;
         else                   n_v = t_v;
         m_out  = n_v;
         m_ramp = (n_v != t_v);
      end
   end

   // Compare on every clock, away from the active edge
   always @(negedge clk) begin
      n_chk++;
      if (longint'(out_word) != m_out || ramping != m_ramp) begin
         n_fail++;
         $display("FAIL %s cycle %0d: out=%0d ramp=%0b expected out=%0d ramp=%0b",
                  tag, cyc, out_word, ramping, m_out, m_ramp);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_fail++;
         $display("FAIL watchdog: cycle %0d actual=running expected=done", cyc);
         finish_run();
      end
   end

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic ticks(input int n, input int gap);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
         cycles(gap);
      end
   endtask

   initial begin
      // R1: reset state
      tag = "R1";
      tgt_word = 32'sd5000; en = 1'b1; tick = 1'b1; slave = 1'b1;
      cycles(3);
      tick = 1'b0; slave = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      cycles(2);

      // R2: ramp upward in steps of 100, ticks spaced apart
      tag = "R2"; tgt_word = 32'sd1000; max_step = 24'd100;
      ticks(5, 2);
      // R6: ticks ignored with en low, target moved meanwhile
      tag = "R6"; en = 1'b0; tgt_word = -32'sd777; max_step = 24'd1;
      ticks(3, 1);
      slave = 1'b1; cycles(3); slave = 1'b0;
      // R6: en high, no tick, no slave -> hold
      en = 1'b1; cycles(4);
      // R2 downward ramp, then R3 final snap
      tag = "R2"; tgt_word = -32'sd700; max_step = 24'd300;
      ticks(4, 0);
      tag = "R3"; ticks(2, 1);
      // R3: within reach
      tgt_word = -32'sd650; max_step = 24'd50; ticks(1, 1);
      // step change in the same cycle as a tick
      tag = "R2"; tgt_word = 32'sd10000; max_step = 24'd10; ticks(2, 0);
      max_step = 24'd1000; ticks(3, 0);
      // R5: slave raised together with a tick mid-ramp
      tag = "R5"; tick = 1'b1; slave = 1'b1; @(negedge clk); tick = 1'b0;
      tgt_word = -32'sd123456; cycles(1);
      tgt_word = 32'sd42; cycles(2);
      slave = 1'b0;
      // R4: zero step copies target
      tag = "R4"; tgt_word = 32'sd9000000; max_step = '0; ticks(1, 1);
      tgt_word = -32'sd9000000; ticks(1, 1);
      // R8: extremes, positive maximum to negative minimum
      tag = "R8"; slave = 1'b1; tgt_word = 32'sh7FFFFFFF; cycles(2); slave = 1'b0;
      tgt_word = 32'sh80000000; max_step = 24'hFFFFFF;
      ticks(300, 0);
      tgt_word = 32'sh7FFFFFFF; max_step = 24'h800000; ticks(520, 0);
      // R7: status held between updates
      tag = "R7"; tgt_word = 32'sd0; max_step = 24'd5; ticks(1, 4);
      tgt_word = 32'sd3; cycles(3);
      cycles(2);
      finish_run();
   end
endmodule